// File: doc/BRIEF.md
# Comma Byte Aligner for a Raw 16-bit Receive Stream

This block sits behind a deserializer that delivers one 16-bit word per user clock with no line code applied. The word boundary is unknown. The deserializer can also slip bits, so a transmitted word may show up shifted by a few bits or with its two bytes exchanged. The aligner looks for a comma byte at every bit position of a 32-bit window. The window holds the previous word and the current word. When alignment is enabled and a comma is found, the block shifts the stream so that the comma sits in the low byte lane of the output word. Every later word then comes out on its true boundary.

Two comma values are recognised, a plus comma and a minus comma, and each can be switched on or off on its own. They are given as 10-bit patterns with a compare mask that keeps only the low eight bits, so the effective bytes are 8'hAE (plus) and 8'h83 (minus). A separate enable gates realignment. This lets the user lock on a comma that is known to be real and ignore look-alike bit patterns that appear inside payload data. The outputs are the aligned word, a sticky aligned flag and a one-cycle realign pulse.

Top module: `comma_byte_aligner`

## Requirements
- R1: After synchronous reset the aligned flag and the realign pulse are low and the shift offset is 0, so the output word equals the previous input word.
- R2: Bit 0 of each word is the earliest on the line. In the 32-bit window {current word, previous word}, window bits 0..15 come from the previous word. A comma exists at offset k (0..15) when window bits k..k+7 equal 8'hAE (plus) or 8'h83 (minus). Only the low 8 bits of the 10-bit patterns (mask 10'b0011111111) are compared, so a near-miss byte such as 8'hAF is not a comma.
- R3: When several offsets hold an enabled comma in the same window, the lowest offset is chosen.
- R4: The output word is window bits off..off+15, registered, so it appears one clock after the input word. At the offset chosen on a lock, the comma byte occupies output bits 7..0.
- R5: Plus and minus detection each have their own enable. A comma of a disabled kind never causes a lock, and with both enables low no lock happens.
- R6: While the align enable is low, the offset is held even if a comma appears at another position.
- R7: The aligned flag rises with the first lock and then stays high until reset.
- R8: The realign output pulses for exactly one cycle on each lock: the first lock after reset, or a lock at an offset different from the held one. The pulse coincides with the first output word taken at the new offset, and it never occurs without the align enable set in the cycle of the input word.
- R9: For a stream of 16'hAEAE followed by 16'h0001 through 16'h007D, repeated, a bit slip of any size (including an 8-bit byte swap) is undone by the next enabled lock on a comma word. From then on the output reproduces the transmitted words exactly.
- R10: A lock request that finds the lowest comma at the offset already held produces no realign pulse and changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | User clock, one word per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| alignEn | input | 1 | Allows a lock to a new offset in this cycle |
| plusEn | input | 1 | Enables plus-comma (8'hAE) detection |
| minusEn | input | 1 | Enables minus-comma (8'h83) detection |
| rxWord | input | 16 | Raw word from the deserializer, bit 0 earliest |
| alignedWord | output | 16 | Word realigned to the comma boundary |
| byteAligned | output | 1 | Sticky flag, high once a lock has occurred |
| realign | output | 1 | One-cycle pulse on a lock to a new offset |

## Verification
The hardest situation to reach is a lock taken just after a bit slip inside a stream whose payload contains look-alike patterns. In that stream the word 16'h0057 creates a spurious plus comma across a word boundary, and the double comma 16'hAEAE offers two candidate lanes, only one of which is right. The stimulus generates the transmitted stream from bit positions and inserts slips of several sizes, including a pure byte swap. It raises the align enable only in the cycle where the true comma word begins within offsets 0..15 of the window. In that cycle the lowest match is provably the correct lane. After each recovery the output is compared word for word against the counter sequence. Directed windows and a random sweep then cover pattern enables, lowest-offset choice and enable hold.

// File: rtl/comma_align_pkg.sv
package comma_align_pkg;

  // Word width delivered per user clock and the derived shift-offset width.
  localparam int unsigned AlignWordW = 16;
  localparam int unsigned AlignOffW  = $clog2(AlignWordW);
  localparam int unsigned AlignWinW  = 2 * AlignWordW;

  // Strobes from the lock control to the datapath.
  typedef struct packed {
    logic                 lock;         // a lock happens this cycle
    logic [AlignOffW-1:0] selOff;       // offset used for this cycle's output
    logic                 alignedNext;  // aligned flag value after this cycle
  } alignStrobe_t;

endpackage

// File: rtl/ca_comma_search.sv
module ca_comma_search
  import comma_align_pkg::*;
#(
  parameter int unsigned        CommaW    = 10,
  parameter logic [CommaW-1:0]  PlusPat   = 10'b0110101110,
  parameter logic [CommaW-1:0]  MinusPat  = 10'b1010000011,
  parameter logic [CommaW-1:0]  CommaMask = 10'b0011111111
) (
  input  logic [AlignWinW-1:0] window,
  input  logic                 plusEn,
  input  logic                 minusEn,
  output logic                 hit,
  output logic [AlignOffW-1:0] hitOff
);

  logic [AlignWordW-1:0] hitVec;

  // One masked comparator pair per candidate bit offset.
  for (genvar k = 0; k < AlignWordW; k++) begin : g_offset
    logic [CommaW-1:0] cand;
    logic              plusHit;
    logic              minusHit;
    assign cand     = window[k +: CommaW];
    assign plusHit  = plusEn  && (((cand ^ PlusPat)  & CommaMask) == '0);
    assign minusHit = minusEn && (((cand ^ MinusPat) & CommaMask) == '0);
    assign hitVec[k] = plusHit || minusHit;
  end

  // Lowest matching offset wins.
  always_comb begin
    hitOff = '0;
    for (int k = AlignWordW - 1; k >= 0; k--) begin
      if (hitVec[k]) hitOff = AlignOffW'(k);
    end
  end

  assign hit = |hitVec;

endmodule

// File: rtl/ca_align_ctrl.sv
module ca_align_ctrl
  import comma_align_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 alignEn,
  input  logic                 hit,
  input  logic [AlignOffW-1:0] hitOff,
  output alignStrobe_t         strobe
);

  logic [AlignOffW-1:0] offReg;
  logic                 alignedReg;
  logic                 lockNow;

  // A lock is taken only when allowed, a comma is present and it either is
  // the first lock or moves the offset.
  assign lockNow = alignEn && hit && (!alignedReg || (hitOff != offReg));

  always_comb begin
    strobe.lock        = lockNow;
    strobe.selOff      = lockNow ? hitOff : offReg;
    strobe.alignedNext = alignedReg || lockNow;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      offReg     <= '0;
      alignedReg <= 1'b0;
    end else if (lockNow) begin
      offReg     <= hitOff;
      alignedReg <= 1'b1;
    end
  end

endmodule

// File: rtl/ca_align_datapath.sv
module ca_align_datapath
  import comma_align_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [AlignWordW-1:0] rxWord,
  input  alignStrobe_t          strobe,
  output logic [AlignWinW-1:0]  window,
  output logic [AlignWordW-1:0] alignedWord,
  output logic                  byteAligned,
  output logic                  realign
);

  logic [AlignWordW-1:0] prevWord;
  logic [AlignWinW-1:0]  stage [AlignOffW+1];

  // Older word in the low half: bit index grows with arrival time.
  assign window   = {rxWord, prevWord};
  assign stage[0] = window;

  // Logarithmic barrel shifter, one stage per offset bit.
  for (genvar b = 0; b < AlignOffW; b++) begin : g_shift
    assign stage[b+1] = strobe.selOff[b] ? (stage[b] >> (1 << b)) : stage[b];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prevWord    <= '0;
      alignedWord <= '0;
      byteAligned <= 1'b0;
      realign     <= 1'b0;
    end else begin
      prevWord    <= rxWord;
      alignedWord <= stage[AlignOffW][AlignWordW-1:0];
      byteAligned <= strobe.alignedNext;
      realign     <= strobe.lock;
    end
  end

endmodule

// File: rtl/comma_byte_aligner.sv
module comma_byte_aligner
  import comma_align_pkg::*;
#(
  parameter int unsigned        CommaW    = 10,
  parameter logic [CommaW-1:0]  PlusPat   = 10'b0110101110,
  parameter logic [CommaW-1:0]  MinusPat  = 10'b1010000011,
  parameter logic [CommaW-1:0]  CommaMask = 10'b0011111111
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  alignEn,
  input  logic                  plusEn,
  input  logic                  minusEn,
  input  logic [AlignWordW-1:0] rxWord,
  output logic [AlignWordW-1:0] alignedWord,
  output logic                  byteAligned,
  output logic                  realign
);

  logic [AlignWinW-1:0] window;
  logic                 hit;
  logic [AlignOffW-1:0] hitOff;
  alignStrobe_t         strobe;

  ca_comma_search #(
    .CommaW   (CommaW),
    .PlusPat  (PlusPat),
    .MinusPat (MinusPat),
    .CommaMask(CommaMask)
  ) i_search (
    .window (window),
    .plusEn (plusEn),
    .minusEn(minusEn),
    .hit    (hit),
    .hitOff (hitOff)
  );

  ca_align_ctrl i_ctrl (
    .clk    (clk),
    .rst    (rst),
    .alignEn(alignEn),
    .hit    (hit),
    .hitOff (hitOff),
    .strobe (strobe)
  );

  ca_align_datapath i_data (
    .clk        (clk),
    .rst        (rst),
    .rxWord     (rxWord),
    .strobe     (strobe),
    .window     (window),
    .alignedWord(alignedWord),
    .byteAligned(byteAligned),
    .realign    (realign)
  );

endmodule

// File: rtl/ca_checker.sv
module ca_checker (
  input logic clk,
  input logic rst,
  input logic alignEn,
  input logic plusEn,
  input logic minusEn,
  input logic byteAligned,
  input logic realign
);

  // R1: first cycle out of reset shows no lock state
  a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!byteAligned && !realign));

  // R7: aligned flag never drops outside reset
  a_r7_aligned_sticky: assert property (@(posedge clk) disable iff (rst)
    byteAligned |=> byteAligned);

  // R8: a pulse always comes with the aligned flag
  a_r8_pulse_with_flag: assert property (@(posedge clk) disable iff (rst)
    realign |-> byteAligned);

  // R6: no pulse unless the enable was set for the input word
  a_r6_pulse_needs_enable: assert property (@(posedge clk) disable iff (rst)
    realign |-> $past(alignEn));

  // R5: no pulse when both comma kinds were disabled
  a_r5_pulse_needs_pattern: assert property (@(posedge clk) disable iff (rst)
    realign |-> ($past(plusEn) || $past(minusEn)));

endmodule

bind comma_byte_aligner ca_checker i_ca_checker (
  .clk        (clk),
  .rst        (rst),
  .alignEn    (alignEn),
  .plusEn     (plusEn),
  .minusEn    (minusEn),
  .byteAligned(byteAligned),
  .realign    (realign)
);

// File: tb/test_comma_byte_aligner.sv
module test_comma_byte_aligner;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        alignEn = 1'b0;
  logic        plusEn = 1'b1;
  logic        minusEn = 1'b1;
  logic [15:0] rxWord = '0;
  logic [15:0] alignedWord;
  logic        byteAligned;
  logic        realign;

  int total = 0;
  int fails = 0;

  // bench-side expectation state
  logic [15:0] drvCur;
  int          offB;
  bit          alignedB;
  logic [15:0] expOut;
  bit          expAl;
  bit          expRe;
  bit          expValid;
  bit          idealValid;
  logic [15:0] idealExp;

  always #10 clk = ~clk;

  comma_byte_aligner i_comma_byte_aligner (
    .clk        (clk),
    .rst        (rst),
    .alignEn    (alignEn),
    .plusEn     (plusEn),
    .minusEn    (minusEn),
    .rxWord     (rxWord),
    .alignedWord(alignedWord),
    .byteAligned(byteAligned),
    .realign    (realign)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // transmitted sequence: 16'hAEAE then 1..125, period 126 words
  function automatic logic [15:0] idealWord(input longint i);
    longint r;
    r = i % 126;
    return (r == 0) ? 16'hAEAE : 16'(r);
  endfunction

  function automatic logic [15:0] idealAt(input longint s);
    logic [15:0] w;
    logic [15:0] res;
    for (int j = 0; j < 16; j++) begin
      w = idealWord((s + j) / 16);
      res[j] = w[(s + j) % 16];
    end
    return res;
  endfunction

  task automatic doReset();
    rst = 1'b1; alignEn = 1'b0; plusEn = 1'b1; minusEn = 1'b1; rxWord = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    drvCur = '0; offB = 0; alignedB = 1'b0;
    expValid = 1'b0; idealValid = 1'b0;
  endtask

  // Spec model: comma bytes per R2, lowest offset per R3, locking per R6/R8/R10.
  task automatic modelStep(input logic [15:0] w, input bit en, input bit pe,
                           input bit me);
    logic [31:0] win;
    logic [7:0]  b;
    bit          found;
    int          hoff;
    bit          lk;
    win = {w, drvCur};
    found = 1'b0; hoff = 0;
    for (int k = 15; k >= 0; k--) begin
      b = win[k +: 8];
      if ((pe && b == 8'hAE) || (me && b == 8'h83)) begin
        found = 1'b1; hoff = k;
      end
    end
    lk = en && found && (!alignedB || hoff != offB);
    if (lk) begin
      offB = hoff; alignedB = 1'b1;
    end
    expOut = 16'(win >> offB);
    expRe = lk; expAl = alignedB; expValid = 1'b1;
    drvCur = w;
  endtask

  task automatic compareModel();
    if (expValid) begin
      chk(alignedWord == expOut, "R4 word", 32'(alignedWord), 32'(expOut));
      chk(byteAligned == expAl, "R7 flag", 32'(byteAligned), 32'(expAl));
      chk(realign == expRe, "R8 pulse", 32'(realign), 32'(expRe));
    end
    if (idealValid)
      chk(alignedWord == idealExp, "R9 recovered", 32'(alignedWord), 32'(idealExp));
  endtask

  task automatic stepD(input logic [15:0] w, input bit en, input bit pe, input bit me);
    rxWord = w; alignEn = en; plusEn = pe; minusEn = me;
    @(negedge clk);
  endtask

  initial begin
    int deltas[8] = '{1, 3, 5, 7, 8, -2, -8, 11};
    longint s;
    longint sPrev;
    longint m;
    longint recIdx;
    bit     recOn;
    bit     contig;
    bit     en;
    logic [15:0] w;

    // ---------------- directed windows ----------------
    doReset();
    chk(byteAligned == 1'b0, "R1 aligned after reset", 32'(byteAligned), 0);
    chk(realign == 1'b0, "R1 realign after reset", 32'(realign), 0);
    stepD(16'h1234, 0, 1, 1);
    stepD(16'h5678, 0, 1, 1);
    chk(alignedWord == 16'h1234, "R1 offset zero", 32'(alignedWord), 32'h1234);
    stepD(16'h00AF, 0, 1, 1);
    stepD(16'h0000, 1, 1, 1);
    chk(alignedWord == 16'h00AF && !byteAligned && !realign, "R2 near-miss byte",
        {byteAligned, realign, 14'd0, alignedWord}, 32'h0000_00AF);
    stepD(16'h83AE, 0, 1, 1);
    stepD(16'h0000, 1, 0, 1);
    chk(alignedWord == 16'h0083, "R5 plus disabled, minus lane", 32'(alignedWord), 32'h0083);
    chk(realign && byteAligned, "R8 first lock pulse", {realign, byteAligned}, 2'b11);
    stepD(16'h83AE, 0, 1, 1);
    chk(alignedWord == 16'hAE00 && !realign, "R8 single pulse", {realign, alignedWord}, 32'hAE00);
    stepD(16'h0000, 1, 1, 1);
    chk(alignedWord == 16'h83AE && realign, "R3 lowest offset", {realign, alignedWord}, 32'h1_83AE);
    stepD(16'h83AE, 0, 1, 1);
    stepD(16'h0000, 1, 1, 0);
    chk(alignedWord == 16'h83AE && !realign && byteAligned, "R10 same offset no pulse",
        {byteAligned, realign, alignedWord}, 32'h2_83AE);
    stepD(16'h83AE, 0, 1, 1);
    stepD(16'h0000, 0, 0, 1);
    chk(alignedWord == 16'h83AE && !realign, "R6 hold without enable",
        {realign, alignedWord}, 32'h83AE);
    stepD(16'h15C0, 0, 1, 1);
    stepD(16'h0000, 1, 1, 0);
    chk(alignedWord == 16'h00AE && realign, "R4 comma in low lane at offset 5",
        {realign, alignedWord}, 32'h1_00AE);
    stepD(16'h83AE, 0, 1, 1);
    chk(alignedWord == 16'h7000, "R4 shifted word", 32'(alignedWord), 32'h7000);
    stepD(16'h0000, 1, 0, 0);
    chk(alignedWord == 16'h041D && !realign && byteAligned, "R5 both kinds disabled",
        {byteAligned, realign, alignedWord}, 32'h2_041D);

    // ---------------- slipped counter stream ----------------
    doReset();
    s = 0; sPrev = -16; recOn = 1'b0; recIdx = 0;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      compareModel();
      if (cyc > 200 && ($urandom % 25) == 0) s = s + deltas[$urandom % 8];
      w = idealAt(s);
      contig = (s == sPrev + 16) && (sPrev >= 0);
      en = 1'b0;
      if (contig) begin
        m = ((sPrev + 2015) / 2016) * 2016;
        if (m - sPrev <= 15) en = (($urandom % 4) != 0);
      end
      rxWord = w; alignEn = en; plusEn = 1'b1; minusEn = 1'b1;
      modelStep(w, en, 1'b1, 1'b1);
      if (!contig) recOn = 1'b0;
      if (en) begin
        recOn = 1'b1;
        recIdx = (sPrev + offB) / 16;
      end
      idealValid = recOn;
      if (recOn) begin
        idealExp = idealWord(recIdx);
        recIdx++;
      end
      sPrev = s;
      s = s + 16;
      @(negedge clk);
    end
    compareModel();

    // ---------------- random sweep ----------------
    doReset();
    for (int cyc = 0; cyc < 3000; cyc++) begin
      compareModel();
      w = 16'($urandom);
      if ($urandom % 2) begin
        int sh;
        logic [7:0] cb;
        sh = $urandom % 9;
        cb = ($urandom % 2) ? 8'hAE : 8'h83;
        w = (w & ~(16'h00FF << sh)) | (16'(cb) << sh);
      end
      en = (($urandom % 3) == 0);
      rxWord = w; alignEn = en;
      plusEn = ($urandom % 4) != 0;
      minusEn = ($urandom % 4) != 0;
      modelStep(w, en, plusEn, minusEn);
      @(negedge clk);
    end
    compareModel();

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog (all requirements) actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule